// File: doc/BRIEF.md
# Eight-Pin Parallel Port Controller

The block is an 8-pin general-purpose I/O port on a small register bus. Software sets three things for each pin through registers: an output latch, a direction bit and a pull-device enable. A fourth register holds per-pin slew control. For each pin the block drives an output value, an output enable, a pullup enable, a pulldown enable and a slew enable to the pad. It also receives the live pad level.

Any pin can be taken over by an on-chip peripheral through a per-pin ownership input. While a peripheral owns a pin, the peripheral supplies the pin's drive direction and output level. The pin's own direction bit still chooses what a read of the data register returns. On the four upper pins, a keyboard-detection function supplies a polarity input for each pin. When that input marks a pin as rising-edge sensitive, the pin's pull enable selects a pulldown instead of a pullup. One pin, set by a parameter and bit 0 by default, reads back the level the port drives onto it, whatever its direction bit says.

The pad controls and the read data are registered. A change at a register or at a peripheral input reaches the pad pins one clock later. Read data appears one clock after the read request and holds until the next read.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After synchronous reset, all four registers read 0 and pad_oe, pad_pu, pad_pd and pad_slew are all 0.
- R2: Address 0 is the data latch, 1 is direction (1 = output), 2 is pull enable and 3 is slew enable. A write with bus_sel=1 and bus_wr=1 takes effect at that clock edge. Direction, pull and slew read back the stored value.
- R3: For a non-special pin, a data read returns the latched bit if its direction bit is 1, and the pad_in bit if its direction bit is 0.
- R4: A data write always loads the latch, even when the pin is an input or is owned by a peripheral.
- R5: For a pin not owned by a peripheral, pad_oe equals its direction bit and pad_out equals its latch bit. Pad controls update one clock after their inputs change.
- R6: For a pin with per_own=1, pad_oe follows per_dir and pad_out follows per_out. Its data-read source is still chosen by its own direction bit.
- R7: A pull device may be on only if the pin's direction bit is 0 and the pin is not driven. This includes a peripheral-owned pin with per_dir=0.
- R8: On pins 7..4, kbi_rise[i-4]=1 turns the pull enable into pad_pd instead of pad_pu. On pins 3..0, the pull enable always drives pad_pu.
- R9: pad_slew is 1 only when the slew bit is set and the pin is driven, either as a port output or as a peripheral output.
- R10: A data read returns the pad_out level on the special pin (bit 0), regardless of its direction bit or pad_in.
- R11: pad_pu and pad_pd are never both 1 for a pin, and neither is 1 while that pin's pad_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Live pad levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pullup enables |
| pad_pd | output | 8 | Pulldown enables |
| pad_slew | output | 8 | Slew-control enables |
| per_own | input | 8 | Peripheral owns pin |
| per_out | input | 8 | Peripheral output level |
| per_dir | input | 8 | Peripheral drive direction (1 = output) |
| kbi_rise | input | 4 | Rising-edge polarity for pins 7..4 |

## Verification
The hardest case to reach is a pin whose read source and drive source disagree. This happens when a peripheral drives a pin whose direction bit is 0, or when a peripheral input sits on a pin whose direction bit is 1. The stimulus sets conflicting values in per_own, per_dir and the direction register together. It then holds pad_in opposite to both the latch and the peripheral level, so each read bit shows which source it came from. The special pin is checked the same way, with pad_in held at the opposite level to the driven value.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_PULL = 2'd2,
    REG_SLEW = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      pe_q,
  output logic [W-1:0]      se_q
);
  // Stores the four per-pin control words; a data write never depends on pin state.
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      pe_q   <= '0;
      se_q   <= '0;
    end else if (wr_en) begin
      case (addr)
        REG_DATA: data_q <= wdata;
        REG_DIR:  dir_q  <= wdata;
        REG_PULL: pe_q   <= wdata;
        default:  se_q   <= wdata;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int W      = 8,
  parameter int KBI_LO = 4,
  parameter int KBI_N  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     data_q,
  input  logic [W-1:0]     dir_q,
  input  logic [W-1:0]     pe_q,
  input  logic [W-1:0]     se_q,
  input  logic [W-1:0]     per_own,
  input  logic [W-1:0]     per_out,
  input  logic [W-1:0]     per_dir,
  input  logic [KBI_N-1:0] kbi_rise,
  output logic [W-1:0]     pad_out,
  output logic [W-1:0]     pad_oe,
  output logic [W-1:0]     pad_pu,
  output logic [W-1:0]     pad_pd,
  output logic [W-1:0]     pad_slew
);
  localparam int KBI_HI = KBI_LO + KBI_N - 1;

  logic [W-1:0] drive_n, level_n, pu_n, pd_n, slew_n, rise_sel;

  for (genvar i = 0; i < W; i++) begin : g_pin
    // Only the keyboard pins can turn their pull device into a pulldown.
    if (i >= KBI_LO && i <= KBI_HI) begin : g_kbi
      assign rise_sel[i] = kbi_rise[i-KBI_LO];
    end else begin : g_plain
      assign rise_sel[i] = 1'b0;
    end

    logic pull_ok;
    assign drive_n[i] = per_own[i] ? per_dir[i] : dir_q[i];
    assign level_n[i] = per_own[i] ? per_out[i] : data_q[i];
    assign pull_ok    = pe_q[i] & ~dir_q[i] & ~drive_n[i];
    assign pu_n[i]    = pull_ok & ~rise_sel[i];
    assign pd_n[i]    = pull_ok &  rise_sel[i];
    assign slew_n[i]  = se_q[i] & drive_n[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out  <= '0;
      pad_oe   <= '0;
      pad_pu   <= '0;
      pad_pd   <= '0;
      pad_slew <= '0;
    end else begin
      pad_out  <= level_n;
      pad_oe   <= drive_n;
      pad_pu   <= pu_n;
      pad_pd   <= pd_n;
      pad_slew <= slew_n;
    end
  end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_pkg::*;
#(
  parameter int W       = 8,
  parameter int SPECIAL = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      data_q,
  input  logic [W-1:0]      dir_q,
  input  logic [W-1:0]      pe_q,
  input  logic [W-1:0]      se_q,
  input  logic [W-1:0]      pad_in,
  input  logic [W-1:0]      pad_out,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] port_view;
  logic [W-1:0] sel_word;

  for (genvar i = 0; i < W; i++) begin : g_view
    if (i == SPECIAL) begin : g_special
      assign port_view[i] = pad_out[i];
    end else begin : g_normal
      assign port_view[i] = dir_q[i] ? data_q[i] : pad_in[i];
    end
  end

  always_comb begin
    case (addr)
      REG_DATA: sel_word = port_view;
      REG_DIR:  sel_word = dir_q;
      REG_PULL: sel_word = pe_q;
      default:  sel_word = se_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel_word;
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int KBI_LO      = 4,
  parameter int KBI_N       = 4,
  parameter int SPECIAL_PIN = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_pu,
  output logic [WIDTH-1:0]  pad_pd,
  output logic [WIDTH-1:0]  pad_slew,
  input  logic [WIDTH-1:0]  per_own,
  input  logic [WIDTH-1:0]  per_out,
  input  logic [WIDTH-1:0]  per_dir,
  input  logic [KBI_N-1:0]  kbi_rise
);
  logic [WIDTH-1:0] data_q, dir_q, pe_q, se_q;
  logic wr_en, rd_en;

  assign wr_en = bus_sel &  bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  gpio_regs #(.W(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(bus_addr), .wdata(bus_wdata),
    .data_q(data_q), .dir_q(dir_q), .pe_q(pe_q), .se_q(se_q)
  );

  gpio_pad_ctl #(.W(WIDTH), .KBI_LO(KBI_LO), .KBI_N(KBI_N)) u_pad (
    .clk(clk), .rst(rst), .data_q(data_q), .dir_q(dir_q), .pe_q(pe_q), .se_q(se_q),
    .per_own(per_own), .per_out(per_out), .per_dir(per_dir), .kbi_rise(kbi_rise),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_slew(pad_slew)
  );

  gpio_rd_mux #(.W(WIDTH), .SPECIAL(SPECIAL_PIN)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(bus_addr), .data_q(data_q),
    .dir_q(dir_q), .pe_q(pe_q), .se_q(se_q), .pad_in(pad_in), .pad_out(pad_out),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic [W-1:0]      pad_out,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      pad_pu,
  input logic [W-1:0]      pad_pd,
  input logic [W-1:0]      pad_slew,
  input logic [W-1:0]      per_own,
  input logic [W-1:0]      per_out,
  input logic [W-1:0]      per_dir,
  input logic [W-1:0]      data_q,
  input logic [W-1:0]      dir_q,
  input logic [W-1:0]      pe_q,
  input logic [W-1:0]      se_q
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_pu == '0 && pad_pd == '0 && pad_slew == '0
                    && data_q == '0 && dir_q == '0 && pe_q == '0 && se_q == '0));

  assert_dir_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == REG_DIR) |=> bus_rdata == $past(dir_q));

  assert_latch_write_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == REG_DATA) |=> data_q == $past(bus_wdata));

  assert_out_source_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pad_out == $past((per_own & per_out) | (~per_own & data_q)));

  assert_oe_source_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pad_oe == $past((per_own & per_dir) | (~per_own & dir_q)));

  assert_pull_dir_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pad_pu | pad_pd) & $past(dir_q | ~pe_q)) == '0);

  assert_slew_drive_R9: assert property (@(posedge clk) disable iff (rst)
    (pad_slew & ~pad_oe) == '0);

  assert_pull_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_pd) == '0);

  assert_no_pull_on_output_R11: assert property (@(posedge clk) disable iff (rst)
    ((pad_pu | pad_pd) & pad_oe) == '0);
endmodule

bind gpio_port_ctrl gpio_port_chk #(.W(WIDTH)) u_chk (.*);

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, pad_in = '0, per_own = '0, per_out = '0, per_dir = '0;
  logic [3:0] kbi_rise = '0;
  logic [7:0] bus_rdata, pad_out, pad_oe, pad_pu, pad_pd, pad_slew;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  gpio_port_ctrl u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_sel = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_all();
    per_own = 0; per_out = 0; per_dir = 0; kbi_rise = 0; pad_in = 0;
    for (int a = 0; a < 4; a++) wr(a[1:0], 8'h00);
    settle();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_pu", pad_pu, 8'h00);
    chk("R1 pad_pd", pad_pd, 8'h00);
    chk("R1 pad_slew", pad_slew, 8'h00);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 register", v, 8'h00);
    end
  endtask

  task automatic t_regmap();
    logic [7:0] v;
    wr(1, 8'hA5); wr(2, 8'h3C); wr(3, 8'hC3);
    rd(1, v); chk("R2 dir readback", v, 8'hA5);
    rd(2, v); chk("R2 pull readback", v, 8'h3C);
    rd(3, v); chk("R2 slew readback", v, 8'hC3);
    clear_all();
  endtask

  task automatic t_data_read();
    logic [7:0] v;
    wr(0, 8'hF0); wr(1, 8'h0F); pad_in = 8'hAA;
    settle();
    rd(0, v); chk("R3 mixed read", v, 8'hA0);
    pad_in = 8'h55;
    rd(0, v); chk("R3 pad change", v, 8'h50);
    clear_all();
  endtask

  task automatic t_write_latch();
    logic [7:0] v;
    wr(0, 8'h3C);
    settle();
    rd(0, v); chk("R4 input pins read pad", v, 8'h00);
    wr(1, 8'hFF);
    settle();
    rd(0, v); chk("R4 latch kept while input", v, 8'h3C);
    per_own = 8'hFF; per_out = 8'h00; per_dir = 8'h00;
    wr(0, 8'h97);
    settle();
    rd(0, v); chk("R4 latch written while owned", v, 8'h96);
    clear_all();
  endtask

  task automatic t_drive();
    wr(1, 8'hF0); wr(0, 8'hA5);
    settle();
    chk("R5 pad_oe", pad_oe, 8'hF0);
    chk("R5 pad_out", pad_out, 8'hA5);
    wr(1, 8'h0F);
    settle();
    chk("R5 pad_oe swap", pad_oe, 8'h0F);
    clear_all();
  endtask

  task automatic t_periph();
    logic [7:0] v;
    wr(1, 8'h0F); wr(0, 8'h00);
    per_own = 8'hF0; per_dir = 8'h30; per_out = 8'hC0; pad_in = 8'hFF;
    settle();
    chk("R6 pad_oe", pad_oe, 8'h3F);
    chk("R6 pad_out", pad_out, 8'hC0);
    rd(0, v); chk("R6 read by own dir", v, 8'hF0);
    clear_all();
  endtask

  task automatic t_pull();
    wr(1, 8'h0F); wr(2, 8'hFF);
    settle();
    chk("R7 pull on inputs", pad_pu, 8'hF0);
    chk("R11 no pull on outputs", (pad_pu | pad_pd) & pad_oe, 8'h00);
    per_own = 8'h0F; per_dir = 8'h00;
    settle();
    chk("R7 dir bit blocks pull", pad_pu, 8'hF0);
    wr(1, 8'h00); per_dir = 8'h03;
    settle();
    chk("R7 peripheral input pull", pad_pu, 8'hFC);
    chk("R11 no pull on driven", (pad_pu | pad_pd) & pad_oe, 8'h00);
    clear_all();
  endtask

  task automatic t_kbi();
    wr(2, 8'hFF); kbi_rise = 4'b0101;
    settle();
    chk("R8 pulldown", pad_pd, 8'h50);
    chk("R8 pullup", pad_pu, 8'hAF);
    chk("R11 exclusive", pad_pu & pad_pd, 8'h00);
    wr(2, 8'h0F);
    settle();
    chk("R8 low pins pullup", pad_pu, 8'h0F);
    chk("R8 no pulldown", pad_pd, 8'h00);
    clear_all();
  endtask

  task automatic t_slew();
    wr(3, 8'hFF); wr(1, 8'h0F);
    settle();
    chk("R9 slew port outputs", pad_slew, 8'h0F);
    per_own = 8'h30; per_dir = 8'h10;
    settle();
    chk("R9 slew peripheral output", pad_slew, 8'h1F);
    wr(3, 8'h00);
    settle();
    chk("R9 slew disabled", pad_slew, 8'h00);
    clear_all();
  endtask

  task automatic t_special();
    logic [7:0] v;
    wr(0, 8'h01); pad_in = 8'h00;
    settle();
    rd(0, v); chk("R10 special reads driven level", v, 8'h01);
    wr(0, 8'h00); wr(1, 8'h01); pad_in = 8'hFF;
    settle();
    rd(0, v); chk("R10 special ignores pad_in", v, 8'hFE);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_data_read();
    t_write_latch();
    t_drive();
    t_periph();
    t_pull();
    t_kbi();
    t_slew();
    t_special();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule